// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the byte address of every transfer in a fixed-length bus burst. A request gives a start address, a transfer size code, a beat-count code and an incrementing/wrapping selector. On a start pulse the block checks and latches the request and then shows the first address. Each advance strobe moves it to the next address. The block raises a final-beat flag on the last transfer and goes idle after that beat is advanced.

In incrementing mode each advance adds the bytes per beat to the address. In wrapping mode the address stays inside a window whose size is the beat count times the bytes per beat. The window is aligned to its own size. When an increment would reach the next window edge, the address returns to the window's lower edge. For example, 8 beats of 4 bytes from 0x34 give 0x34, 0x38, 0x3C, 0x20, 0x24, 0x28, 0x2C, 0x30.

A request is rejected when its start address is not aligned to the transfer size or when one of its codes is unsupported. A rejected request raises an error pulse and no burst starts.

Top module: `burst_addr_gen`

## Requirements
- R1: Reset is synchronous and active high. After reset `active`, `final_beat` and `req_err` are all 0.
- R2: A start pulse with a valid request sets `active` to 1 in the next cycle, with `cur_addr` equal to the start address.
- R3: In incrementing mode (`req_wrap`=0), each advance while active and not on the final beat adds 2^`req_size` bytes to `cur_addr`, modulo 2^ADDR_W.
- R4: In wrapping mode (`req_wrap`=1), the window is beats × 2^`req_size` bytes, aligned to its size. Each advance gives the window base plus ((offset + bytes) mod window), so the address never leaves the start address's window.
- R5: Beat-count code 0, 1 and 2 select 4, 8 and 16 beats. `final_beat` is 1 exactly while the last beat is shown. An advance on the final beat clears `active` in the next cycle.
- R6: A request is invalid when any of these holds: the start address has a nonzero bit below bit `req_size`, `req_size` > 3, or the beat-count code is 3. An invalid start pulse gives `req_err`=1 for exactly the next cycle and `active`=0, and no burst starts.
- R7: A start pulse while a burst is active abandons that burst and loads the new request on the same edge. A start takes priority over a simultaneous advance.
- R8: An advance while idle has no effect: `active` stays 0 and `req_err` stays 0.
- R9: While active without an advance or start, `cur_addr` and `final_beat` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse; latches the request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 3 | Transfer size code; bytes per beat = 2^code, codes 0..3 valid |
| req_len | input | 2 | Beat-count code: 0=4, 1=8, 2=16, 3 invalid |
| req_wrap | input | 1 | 1 selects wrapping, 0 incrementing |
| advance | input | 1 | Beat-advance strobe |
| cur_addr | output | ADDR_W | Address of the current beat |
| active | output | 1 | A burst is in progress |
| final_beat | output | 1 | Current beat is the last one |
| req_err | output | 1 | One-cycle pulse after a rejected request |

## Verification
The bench builds the block with its default 32-bit address width. At that width, start addresses near the top of the address space are reachable. The bench uses them to show that a wrapping window near 0xFFFFFFFF stays closed, and that an incrementing burst rolls over modulo 2^32. Random requests cover all size codes, including the unsupported ones, with deliberately misaligned addresses and all beat-count codes. They are mixed with restarts in mid-burst and with idle advances. Directed sequences replay the three 8-beat wrapping examples with 4-byte beats and a 16-beat, 8-byte wrap.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef struct packed {
        logic [2:0] size;
        logic [1:0] len;
        logic       wrap;
    } burst_cfg_t;

    localparam int CNT_W = 4;

    // Remaining beats after the first one: 3, 7 or 15.
    function automatic logic [CNT_W-1:0] beats_minus1(input logic [1:0] len);
        return CNT_W'((4 << len) - 1);
    endfunction

    // log2 of the wrap window in bytes.
    function automatic logic [3:0] win_log2(input logic [1:0] len, input logic [2:0] size);
        return 4'(len) + 4'd2 + 4'(size);
    endfunction

endpackage

// File: rtl/req_checker.sv
module req_checker #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        len_i,
    output logic              bad_o
);
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask = (ADDR_W'(1) << size_i[1:0]) - ADDR_W'(1);
        bad_o    = size_i[2] || (len_i == 2'd3) || ((addr_i & low_mask) != '0);
    end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
    import burst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  burst_cfg_t        cfg_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0] bytes;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        bytes    = ADDR_W'(1) << cfg_i.size[1:0];
        win_mask = (ADDR_W'(1) << win_log2(cfg_i.len, cfg_i.size)) - ADDR_W'(1);
        sum      = addr_i + bytes;
        if (cfg_i.wrap)
            next_o = (addr_i & ~win_mask) | (sum & win_mask);
        else
            next_o = sum;
    end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [1:0]       len_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load_i)
            remain <= beats_minus1(len_i);
        else if (dec_i)
            remain <= remain - 1'b1;
    end

    assign zero_o = (remain == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec_i && !load_i |-> remain != '0);  // R5
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_len,
    input  logic              req_wrap,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active,
    output logic              final_beat,
    output logic              req_err
);
    burst_cfg_t        cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;
    logic              active_q;
    logic              err_q;
    logic              bad;
    logic              cnt_zero;
    logic              load;
    logic              step;

    req_checker #(.ADDR_W(ADDR_W)) u_chk (
        .addr_i (req_addr),
        .size_i (req_size),
        .len_i  (req_len),
        .bad_o  (bad)
    );

    addr_stepper #(.ADDR_W(ADDR_W)) u_step (
        .addr_i (addr_q),
        .cfg_i  (cfg_q),
        .next_o (addr_nx)
    );

    assign load = req_start && !bad;
    assign step = !req_start && active_q && advance && !cnt_zero;

    beat_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .len_i  (req_len),
        .dec_i  (step),
        .zero_o (cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            cfg_q    <= '0;
            active_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= req_start && bad;
            if (req_start) begin
                active_q <= !bad;
                if (!bad) begin
                    addr_q <= req_addr;
                    cfg_q  <= '{size: req_size, len: req_len, wrap: req_wrap};
                end
            end else if (active_q && advance) begin
                if (cnt_zero)
                    active_q <= 1'b0;
                else
                    addr_q <= addr_nx;
            end
        end
    end

    assign cur_addr   = addr_q;
    assign active     = active_q;
    assign final_beat = active_q && cnt_zero;
    assign req_err    = err_q;

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !active);  // R6
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        req_start && !bad |=> active && cur_addr == $past(req_addr));  // R2
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        !active && !req_start |=> !active && !req_err);  // R8
    AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (rst)
        final_beat && advance && !req_start |=> !active);  // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        active && !advance && !req_start |=> $stable(cur_addr) && $stable(final_beat));  // R9
    AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        active && cfg_q.wrap && advance && !final_beat && !req_start
        |=> (cur_addr >> win_log2(cfg_q.len, cfg_q.size))
            == ($past(cur_addr) >> win_log2($past(cfg_q.len), $past(cfg_q.size))));  // R4
    AST_INCR_STEP: assert property (@(posedge clk) disable iff (rst)
        active && !cfg_q.wrap && advance && !final_beat && !req_start
        |=> cur_addr - $past(cur_addr) == (ADDR_W'(1) << $past(cfg_q.size[1:0])));  // R3
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_start, req_wrap, advance;
    logic [AW-1:0] req_addr;
    logic [2:0]    req_size;
    logic [1:0]    req_len;
    logic [AW-1:0] cur_addr;
    logic          active, final_beat, req_err;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic          m_active, m_err;
    logic [AW-1:0] m_addr;
    int            m_rem, m_beats, m_size;
    logic          m_wrap;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_size(req_size), .req_len(req_len), .req_wrap(req_wrap),
        .advance(advance), .cur_addr(cur_addr), .active(active),
        .final_beat(final_beat), .req_err(req_err)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a, input int size,
                                                input int beats, input logic wrap);
        longint unsigned win, bytes, base, off;
        bytes = 64'(1) << size;
        if (!wrap) return a + AW'(bytes);
        win  = 64'(beats) * bytes;
        base = (64'(a) / win) * win;
        off  = (64'(a) - base + bytes) % win;
        return AW'(base + off);
    endfunction

    function automatic logic req_bad(input logic [AW-1:0] a, input logic [2:0] s, input logic [1:0] l);
        if (s > 3 || l == 2'd3) return 1'b1;
        return (a % (AW'(1) << s)) != 0;
    endfunction

    // one clock: inputs already set; update model, clock, compare
    task automatic cycle(input string tag);
        logic bad;
        bad   = req_bad(req_addr, req_size, req_len);
        m_err = req_start && bad;
        if (req_start) begin
            m_active = !bad;
            if (!bad) begin
                m_addr  = req_addr;
                m_size  = int'(req_size);
                m_beats = 4 << req_len;
                m_wrap  = req_wrap;
                m_rem   = m_beats - 1;
            end
        end else if (m_active && advance) begin
            if (m_rem == 0) m_active = 1'b0;
            else begin
                m_addr = ref_next(m_addr, m_size, m_beats, m_wrap);
                m_rem--;
            end
        end
        @(posedge clk); #1;
        chk({tag, " R6 err"}, AW'(req_err), AW'(m_err));
        chk({tag, " R5 active"}, AW'(active), AW'(m_active));
        if (m_active) begin
            chk({tag, m_wrap ? " R4 addr" : " R3 addr"}, cur_addr, m_addr);
            chk({tag, " R5 final"}, AW'(final_beat), AW'(m_rem == 0));
        end
        @(negedge clk);
        req_start = 1'b0;
        advance   = 1'b0;
    endtask

    task automatic launch(input logic [AW-1:0] a, input logic [2:0] s,
                          input logic [1:0] l, input logic w, input string tag);
        req_start = 1'b1; req_addr = a; req_size = s; req_len = l; req_wrap = w;
        cycle(tag);
    endtask

    task automatic wrap_seq(input logic [AW-1:0] a, input logic [AW-1:0] e [8]);
        launch(a, 3'd2, 2'd1, 1'b1, "R2 start");
        for (int i = 0; i < 8; i++) begin
            chk("R4 example", cur_addr, e[i]);
            advance = 1'b1;
            cycle("R4 walk");
        end
        chk("R5 idle after last", AW'(active), '0);
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_start = 0; advance = 0; req_addr = '0;
        req_size = '0; req_len = '0; req_wrap = 0;
        m_active = 0; m_err = 0; m_addr = '0; m_rem = 0; m_beats = 4; m_size = 0; m_wrap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 active", AW'(active), '0);
        chk("R1 final", AW'(final_beat), '0);
        chk("R1 err", AW'(req_err), '0);

        // idle advance ignored
        advance = 1'b1; cycle("R8 idle advance");
        chk("R8 still idle", AW'(active), '0);

        wrap_seq(32'h04, '{32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h18, 32'h1C, 32'h00});
        wrap_seq(32'h10, '{32'h10, 32'h14, 32'h18, 32'h1C, 32'h00, 32'h04, 32'h08, 32'h0C});
        wrap_seq(32'h34, '{32'h34, 32'h38, 32'h3C, 32'h20, 32'h24, 32'h28, 32'h2C, 32'h30});

        // 16 beats x 8 bytes near top of address space
        launch(32'hFFFF_FFF8, 3'd3, 2'd2, 1'b1, "R4 top");
        for (int i = 0; i < 16; i++) begin advance = 1'b1; cycle("R4 top walk"); end
        // incrementing rollover
        launch(32'hFFFF_FFFC, 3'd2, 2'd0, 1'b0, "R3 roll");
        advance = 1'b1; cycle("R3 roll step");
        chk("R3 rollover", cur_addr, 32'h0);
        // hold
        cycle("R9 hold");
        chk("R9 hold addr", cur_addr, 32'h0);
        // restart mid-burst with simultaneous advance
        advance = 1'b1;
        launch(32'h100, 3'd0, 2'd0, 1'b0, "R7 restart");
        chk("R7 new addr", cur_addr, 32'h100);
        // misaligned start aborts
        launch(32'h102, 3'd2, 2'd1, 1'b1, "R6 misaligned");
        chk("R6 err pulse", AW'(req_err), 1);
        chk("R6 no burst", AW'(active), 0);
        cycle("R6 err clears");
        launch(32'h0, 3'd5, 2'd0, 1'b0, "R6 bad size");
        launch(32'h0, 3'd0, 2'd3, 1'b0, "R6 bad len");

        for (int n = 0; n < 4000; n++) begin
            logic [2:0] s;
            logic [AW-1:0] a;
            s = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
            a = $urandom;
            if ($urandom % 8 != 0) a = a & ~((AW'(1) << s[1:0]) - 1);
            req_start = ($urandom % 12 == 0);
            advance   = ($urandom % 10 < 6);
            req_addr  = a;
            req_size  = s;
            req_len   = 2'($urandom % 4);
            req_wrap  = 1'($urandom);
            cycle("random");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule